// File: doc/BRIEF.md
# Asynchronous Trigger Capture and Busy Controller

This block takes a trigger pulse that may arrive at any phase of the 40 MHz system clock. It turns that pulse into two timing signals. The sample-hold line rises straight from the trigger's leading edge through a flop clocked by the trigger itself, so it keeps the full timing resolution of the input. The trigger's trailing edge passes through a two-flop synchroniser. That edge then produces a one-cycle transfer-start strobe, which every front end sees in the same clock cycle.

A busy flag is raised by each accepted trigger and holds off later triggers until software asks for it to be cleared. A trigger whose synchronised trailing edge falls in the same cycle as the clear request still wins. It is counted and it keeps the flag high, so the trigger is neither lost nor left with the flag stuck.

The sample-hold line is released asynchronously after a programmed number of clock cycles. The accepted-trigger counter wraps and has a synchronous clear. A sticky flag reports any trigger pulse too short for the synchroniser to sample.

Top module: `trig_busy_ctrl`

## Requirements
- R1: While rst_n is low, hold_out, xfer_start, busy_out and short_err are 0 and trig_count is 0.
- R2: When busy_out is 0, a rising edge on trig_in drives hold_out to 1 before the next clock edge.
- R3: The trigger's falling edge is sampled by a two-flop synchroniser. xfer_start is then high for exactly one cycle, starting at the third rising clock edge after the falling edge.
- R4: busy_out goes to 1 at the edge that raises xfer_start. It stays at 1 while busy_clr is low.
- R5: A trigger whose rising edge arrives while busy_out is 1 leaves hold_out at 0. If it is not a coincident case (R6), it produces no xfer_start and leaves trig_count unchanged.
- R6: If busy_clr is high at the edge where a synchronised trailing edge is accepted, the trigger takes priority. xfer_start pulses, trig_count increments and busy_out stays 1.
- R7: Let N be hold_cycles, with 0 treated as 1. hold_out is cleared at the N-th rising edge after the edge that raised xfer_start, and it is still high after edge N-1.
- R8: Each accepted trigger adds one to trig_count, modulo 2^COUNT_W.
- R9: cnt_clr synchronously sets trig_count to 0. If a trigger is accepted at the same edge, the result is 1.
- R10: A trigger pulse with both edges between two adjacent clock edges produces no xfer_start and no count. At the third edge after it, short_err becomes 1 and hold_out is released. short_err stays 1 until reset.
- R11: busy_clr high at an edge with no accepted trigger returns busy_out to 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Trigger pulse, asynchronous to clk |
| busy_clr | input | 1 | Request to drop the busy flag |
| cnt_clr | input | 1 | Synchronous clear of the trigger counter |
| hold_cycles | input | HOLD_W | Clock cycles from strobe to hold release (0 means 1) |
| hold_out | output | 1 | Sample-hold line, set by the trigger's leading edge |
| xfer_start | output | 1 | One-cycle transfer-start strobe |
| busy_out | output | 1 | Busy flag |
| trig_count | output | COUNT_W | Accepted-trigger counter |
| short_err | output | 1 | Sticky flag for a pulse too short to sample |

## Verification
The embedded properties check the following on every cycle:
- the strobe is one cycle wide;
- the busy flag persists without a clear and drops after a clear that has no trigger;
- a coincident trigger wins;
- the counter steps by one per acceptance and returns to zero after a clear;
- the hold line rises only while not busy and is low whenever the release pulse is present;
- the error flag is sticky.

Other behaviour depends on exact edge placement and is shown only by the bench's sweeps over trigger phase, pulse width and hold delay. This covers the asynchronous rise of hold before any clock edge, the exact edge counts for the strobe and the hold release, and the counter wrap. It also covers the placement of a clear request on the accepting edge and the detection of a sub-cycle pulse.

// File: rtl/trgc_pkg.sv
`timescale 1ns/100ps
package trgc_pkg;

  // Hold delay in cycles; a programmed zero is promoted to one cycle.
  function automatic int eff_hold(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // A synchronised trailing edge is taken when idle, or when it meets a clear.
  function automatic logic accept_rule(input logic fall, input logic busy, input logic clr);
    return fall & (~busy | clr);
  endfunction

  // Next busy state: acceptance dominates the clear request.
  function automatic logic busy_next(input logic acc, input logic busy, input logic clr);
    return acc ? 1'b1 : (clr ? 1'b0 : busy);
  endfunction

endpackage

// File: rtl/trgc_sync.sv
`timescale 1ns/100ps
module trgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LEN-2:0], d};
  end

  assign q      = sh[STAGES-1];
  assign q_prev = sh[STAGES];
endmodule

// File: rtl/trgc_hold.sv
`timescale 1ns/100ps
module trgc_hold #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              busy,
  input  logic              accept,
  input  logic              short_evt,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              hold_q,
  output logic              rel_pulse
);
  logic [HOLD_W-1:0] rel_cnt;
  logic              hold_clr;
  logic [HOLD_W-1:0] load_val;

  assign load_val = HOLD_W'(trgc_pkg::eff_hold(int'(hold_cycles)));
  assign hold_clr = rel_pulse | ~rst_n;

  // Leading-edge capture: clocked by the trigger itself, never by clk.
  always_ff @(posedge trig_in or posedge hold_clr) begin
    if (hold_clr)   hold_q <= 1'b0;
    else if (!busy) hold_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt   <= '0;
      rel_pulse <= 1'b0;
    end else begin
      rel_pulse <= (rel_cnt == HOLD_W'(1)) | short_evt;
      if (accept)              rel_cnt <= load_val;
      else if (rel_cnt != '0)  rel_cnt <= rel_cnt - HOLD_W'(1);
    end
  end

  // R7: while the release pulse is present the hold line is low.
  assert_hold_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> !hold_q);

  // R5: hold can only have risen during an interval with busy low.
  assert_hold_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> !busy);
endmodule

// File: rtl/trgc_ctrl.sv
`timescale 1ns/100ps
module trgc_ctrl #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fall_evt,
  input  logic               short_evt,
  input  logic               busy_clr,
  input  logic               cnt_clr,
  output logic               accept,
  output logic               busy,
  output logic               xfer_start,
  output logic [COUNT_W-1:0] count,
  output logic               short_err
);
  function automatic logic [COUNT_W-1:0] count_next(
    input logic [COUNT_W-1:0] c, input logic clr, input logic acc);
    logic [COUNT_W-1:0] base;
    base = clr ? '0 : c;
    return acc ? base + COUNT_W'(1) : base;
  endfunction

  assign accept = trgc_pkg::accept_rule(fall_evt, busy, busy_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      xfer_start <= 1'b0;
      count      <= '0;
      short_err  <= 1'b0;
    end else begin
      busy       <= trgc_pkg::busy_next(accept, busy, busy_clr);
      xfer_start <= accept;
      count      <= count_next(count, cnt_clr, accept);
      if (short_evt) short_err <= 1'b1;
    end
  end

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !busy_clr |=> busy);

  assert_coincident_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt && busy && busy_clr |=> busy && xfer_start);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !$past(cnt_clr) -> count == $past(count) + COUNT_W'(1));

  assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr && !fall_evt |=> count == '0);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |=> short_err);

  assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_clr && !fall_evt |=> !busy);
endmodule

// File: rtl/trig_busy_ctrl.sv
`timescale 1ns/100ps
module trig_busy_ctrl #(
  parameter int COUNT_W     = 32,
  parameter int HOLD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_in,
  input  logic               busy_clr,
  input  logic               cnt_clr,
  input  logic [HOLD_W-1:0]  hold_cycles,
  output logic               hold_out,
  output logic               xfer_start,
  output logic               busy_out,
  output logic [COUNT_W-1:0] trig_count,
  output logic               short_err
);
  logic tog_q;
  logic lvl_q, lvl_prev;
  logic tsy_q, tsy_prev;
  logic fall_evt, tog_evt, short_evt;
  logic accept, rel_pulse;

  // Every leading edge flips this flop, however short the pulse.
  always_ff @(posedge trig_in or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  trgc_sync #(.STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk(clk), .rst_n(rst_n), .d(trig_in), .q(lvl_q), .q_prev(lvl_prev));

  trgc_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
    .clk(clk), .rst_n(rst_n), .d(tog_q), .q(tsy_q), .q_prev(tsy_prev));

  assign fall_evt  = lvl_prev & ~lvl_q;
  assign tog_evt   = tsy_q ^ tsy_prev;
  assign short_evt = tog_evt & ~lvl_q;

  trgc_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .short_evt(short_evt),
    .busy_clr(busy_clr), .cnt_clr(cnt_clr), .accept(accept), .busy(busy_out),
    .xfer_start(xfer_start), .count(trig_count), .short_err(short_err));

  trgc_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .busy(busy_out),
    .accept(accept), .short_evt(short_evt), .hold_cycles(hold_cycles),
    .hold_q(hold_out), .rel_pulse(rel_pulse));

  // R10: an unseen pulse never yields a strobe on the following edge.
  assert_short_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt && !fall_evt |=> !xfer_start);
endmodule

// File: tb/trig_busy_ctrl_bench.sv
`timescale 1ns/100ps
module trig_busy_ctrl_bench;
  localparam int CW = 4;
  localparam int HW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig_in = 1'b0;
  logic          busy_clr = 1'b0;
  logic          cnt_clr = 1'b0;
  logic [HW-1:0] hold_cycles = '0;
  logic          hold_out, xfer_start, busy_out, short_err;
  logic [CW-1:0] trig_count;

  int checks = 0;
  int failures = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_busy_ctrl #(.COUNT_W(CW), .HOLD_W(HW)) u_trig_busy_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .busy_clr(busy_clr),
    .cnt_clr(cnt_clr), .hold_cycles(hold_cycles), .hold_out(hold_out),
    .xfer_start(xfer_start), .busy_out(busy_out), .trig_count(trig_count),
    .short_err(short_err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Rise at ph ns after an edge, check hold, fall ph ns after edge hi,
  // then return 1 ns after the third edge following the fall.
  task automatic fire(input int ph, input int hi, input bit exp_hold, input string req);
    @(posedge clk); #(ph); trig_in = 1'b1;
    #0.5 chk(hold_out == exp_hold, req, hold_out, exp_hold);
    repeat (hi) @(posedge clk);
    #(ph); trig_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic clear_busy();
    @(posedge clk); #1 busy_clr = 1'b1;
    @(posedge clk); #1 busy_clr = 1'b0;
  endtask

  initial begin
    #3;
    chk(hold_out == 0 && xfer_start == 0 && busy_out == 0 && short_err == 0,
        "R1 outputs", {hold_out, xfer_start, busy_out, short_err}, 0);
    chk(trig_count == 0, "R1 count", trig_count, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Sweep hold delay, trigger phase and width; counter wraps at 16.
    for (int n = 0; n <= 5; n++) begin
      for (int ph = 1; ph <= 6; ph++) begin
        int eff;
        hold_cycles = HW'(n);
        eff = (n == 0) ? 1 : n;
        fire(ph, 1 + (ph % 3), 1'b1, "R2 hold rise");
        exp_cnt = (exp_cnt + 1) % (1 << CW);
        chk(xfer_start == 1, "R3 strobe", xfer_start, 1);
        chk(busy_out == 1, "R4 busy set", busy_out, 1);
        chk(trig_count == CW'(exp_cnt), "R8 count", trig_count, exp_cnt);
        for (int k = 1; k <= eff; k++) begin
          @(posedge clk); #1;
          chk(hold_out == (k < eff), "R7 hold release", hold_out, (k < eff));
          if (k == 1) chk(xfer_start == 0, "R3 single cycle", xfer_start, 0);
        end
        @(posedge clk); #1 chk(busy_out == 1, "R4 busy kept", busy_out, 1);
        clear_busy();
        chk(busy_out == 0, "R11 busy drop", busy_out, 0);
      end
    end

    // Trigger ignored while busy.
    hold_cycles = HW'(2);
    fire(3, 1, 1'b1, "R2 hold rise");
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    repeat (3) @(posedge clk);
    fire(3, 1, 1'b0, "R5 hold blocked");
    chk(xfer_start == 0, "R5 no strobe", xfer_start, 0);
    repeat (2) @(posedge clk);
    #1 chk(trig_count == CW'(exp_cnt), "R5 count kept", trig_count, exp_cnt);
    chk(busy_out == 1, "R5 busy kept", busy_out, 1);

    // Clear request on the accepting edge.
    @(posedge clk); #2 trig_in = 1'b1;
    #0.5 chk(hold_out == 0, "R5 hold blocked", hold_out, 0);
    @(posedge clk); #2 trig_in = 1'b0;
    @(posedge clk); @(posedge clk); #1 busy_clr = 1'b1;
    @(posedge clk); #1 busy_clr = 1'b0;
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    chk(xfer_start == 1, "R6 strobe", xfer_start, 1);
    chk(busy_out == 1, "R6 busy", busy_out, 1);
    chk(trig_count == CW'(exp_cnt), "R6 count", trig_count, exp_cnt);
    @(posedge clk); #1 chk(busy_out == 1, "R6 busy stays", busy_out, 1);
    clear_busy();
    chk(busy_out == 0, "R11 busy drop", busy_out, 0);

    // Counter clear, alone and with an acceptance.
    @(posedge clk); #1 cnt_clr = 1'b1;
    @(posedge clk); #1 cnt_clr = 1'b0;
    exp_cnt = 0;
    chk(trig_count == 0, "R9 clear", trig_count, 0);
    @(posedge clk); #5 trig_in = 1'b1;
    @(posedge clk); #5 trig_in = 1'b0;
    @(posedge clk); @(posedge clk); #1 cnt_clr = 1'b1;
    @(posedge clk); #1 cnt_clr = 1'b0;
    exp_cnt = 1;
    chk(trig_count == 1, "R9 clear with accept", trig_count, 1);
    repeat (3) @(posedge clk);
    clear_busy();

    // Sub-cycle pulse.
    @(posedge clk); #2 trig_in = 1'b1;
    #0.5 chk(hold_out == 1, "R2 hold rise short", hold_out, 1);
    #1.5 trig_in = 1'b0;
    @(posedge clk); @(posedge clk);
    #1 chk(short_err == 0, "R10 not yet", short_err, 0);
    @(posedge clk); #1;
    chk(short_err == 1, "R10 flag", short_err, 1);
    chk(hold_out == 0, "R10 hold released", hold_out, 0);
    chk(xfer_start == 0, "R10 no strobe", xfer_start, 0);
    chk(trig_count == CW'(exp_cnt), "R10 count kept", trig_count, exp_cnt);
    repeat (4) @(posedge clk);
    #1 chk(short_err == 1 && xfer_start == 0, "R10 sticky", short_err, 1);

    // Reset again.
    rst_n = 1'b0;
    #1 chk(short_err == 0 && busy_out == 0 && trig_count == 0 && hold_out == 0,
           "R1 reset", {short_err, busy_out, hold_out}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule